// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block drives the fixed power-up command sequence of a DDR2 memory onto a command port. A single-cycle start pulse samples three configuration inputs: CAS latency, write recovery in clock cycles, and the number of populated memory modules. From these the block builds the mode-register and extended-mode-register words, then steps through the sequence one command at a time.

Each command is presented as a 3-bit command code, a 2-bit mode-register select and an address/data word, qualified by a valid strobe. A command stays on the port until the downstream side accepts it with ready. After the opening NOP and after the mode-register load that resets the DLL, the block waits a parameterised number of clock cycles before it sends the next command. When the last command is accepted a done flag rises and stays high until the next start. A configuration that cannot be encoded raises an error flag instead, and no command is sent.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, cmd_valid_o, busy_o, done_o and cfg_err_o are all 0.
- R2: An accepted start produces exactly these commands, in this order, as (code, select): NOP (7,0); precharge (2,0); EMR2 (0,2); EMR3 (0,3); EMR (0,1); MR (0,0); precharge (2,0); REF_COUNT refreshes (1,0), default 4; MR (0,0); EMR (0,1); EMR (0,1). NOP, refresh, EMR2 and EMR3 carry address 0, and both precharges carry 0x400.
- R3: The MR word has bits [2:0] = 2, bits [6:4] = CAS latency and bits [11:9] = write recovery minus one. Bit 8 is set on the first MR load only.
- R4: The EMR word is 0x040 with one module. With two modules it is 0x006 (0x004 termination, bit 1 reduced drive).
- R5: The first EMR after the refreshes carries the EMR word OR 0x380. The final EMR carries the plain EMR word.
- R6: After the NOP and after the first MR are accepted, cmd_valid_o stays low for WAIT_CYC cycles. The next accepted command comes WAIT_CYC+1 cycles after them when ready is held high. Every other command follows its predecessor in the next cycle.
- R7: While cmd_valid_o is high and cmd_ready_i is low, the command fields and valid stay unchanged in the following cycle.
- R8: busy_o is high from the cycle after an accepted start until the last command is accepted. done_o is then high until the next start and drops in the cycle after it.
- R9: A start whose CAS latency is not 3..5, whose write recovery is not 2..6, or whose module count is not 1 or 2, sets cfg_err_o and sends no command. A later valid start clears cfg_err_o.
- R10: A start pulse while busy_o is high is ignored: it neither restarts nor reorders the sequence.
- R11: Configuration inputs are sampled only at an accepted start. Changes to them during the sequence do not alter the words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| cas_lat_i | input | 3 | CAS latency in cycles |
| wr_rec_i | input | 3 | Write recovery in cycles |
| mod_cnt_i | input | 2 | Number of populated modules |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Downstream accepts command |
| cmd_code_o | output | 3 | Command code |
| cmd_sel_o | output | 2 | Mode-register select |
| cmd_addr_o | output | ADDR_W | Address/data word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| cfg_err_o | output | 1 | Last start had an unusable configuration |

## Verification
The hardest case to reach is a start pulse that lands while a command is stalled by a low ready, and that comes with different configuration inputs at the same moment. It could then corrupt both the step order and the latched mode words. The stimulus runs one sequence with a ready pattern that stalls every third cycle. Partway through that sequence it changes all three configuration inputs and pulses start. The scoreboard then has to see exactly the words computed from the first configuration, and it checks that every stalled command is held.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  localparam int WORD_W = 12;

  typedef enum logic [2:0] {
    CMD_MRS = 3'd0,
    CMD_REF = 3'd1,
    CMD_PRE = 3'd2,
    CMD_WR  = 3'd4,
    CMD_RD  = 3'd5,
    CMD_NOP = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_MR   = 2'd0,
    SEL_EMR  = 2'd1,
    SEL_EMR2 = 2'd2,
    SEL_EMR3 = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  localparam logic [WORD_W-1:0] MR_BURST4   = 12'h002;
  localparam logic [WORD_W-1:0] MR_DLL_RST  = 12'h100;
  localparam logic [WORD_W-1:0] EMR_TERM150 = 12'h040;
  localparam logic [WORD_W-1:0] EMR_TERM75  = 12'h004;
  localparam logic [WORD_W-1:0] EMR_DRV_RED = 12'h002;
  localparam logic [WORD_W-1:0] EMR_OCD_DEF = 12'h380;
  localparam logic [WORD_W-1:0] PRE_ALLBANK = 12'h400;

  function automatic logic cfg_usable(input logic [2:0] cas,
                                      input logic [2:0] wr,
                                      input logic [1:0] mods);
    logic cas_ok, wr_ok, mods_ok;
    cas_ok  = (cas >= 3'd3) && (cas <= 3'd5);
    wr_ok   = (wr >= 3'd2) && (wr <= 3'd6);
    mods_ok = (mods == 2'd1) || (mods == 2'd2);
    return cas_ok && wr_ok && mods_ok;
  endfunction

  function automatic logic [WORD_W-1:0] mr_word(input logic [2:0] cas,
                                                input logic [2:0] wr);
    logic [WORD_W-1:0] w;
    w         = MR_BURST4;
    w[6:4]    = cas;
    w[11:9]   = wr - 3'd1;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] emr_word(input logic [1:0] mods);
    if (mods == 2'd2) return EMR_TERM75 | EMR_DRV_RED;
    return EMR_TERM150;
  endfunction
endpackage

// File: rtl/ddr2_mode_words.sv
module ddr2_mode_words
  import ddr2_init_pkg::*;
(
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        wr_rec_i,
  input  logic [1:0]        mod_cnt_i,
  output logic              cfg_ok_o,
  output logic [WORD_W-1:0] mr_o,
  output logic [WORD_W-1:0] emr_o
);
  always_comb begin
    cfg_ok_o = cfg_usable(cas_lat_i, wr_rec_i, mod_cnt_i);
    mr_o     = mr_word(cas_lat_i, wr_rec_i);
    emr_o    = emr_word(mod_cnt_i);
  end
endmodule

// File: rtl/ddr2_step_decode.sv
module ddr2_step_decode
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int REF_COUNT = 4,
  parameter int STEP_W    = 4
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [WORD_W-1:0] mr_i,
  input  logic [WORD_W-1:0] emr_i,
  output logic [2:0]        code_o,
  output logic [1:0]        sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wait_after_o,
  output logic              last_o
);
  localparam int S_REF0 = 7;
  localparam int S_MR2  = S_REF0 + REF_COUNT;
  localparam int S_OCD  = S_MR2 + 1;
  localparam int S_EXIT = S_MR2 + 2;

  int unsigned s;
  logic [WORD_W-1:0] word;

  always_comb begin
    s            = 32'(step_i);
    code_o       = CMD_NOP;
    sel_o        = SEL_MR;
    word         = '0;
    wait_after_o = 1'b0;
    last_o       = 1'b0;
    if (s == 0) begin
      wait_after_o = 1'b1;
    end else if (s == 1 || s == 6) begin
      code_o = CMD_PRE;
      word   = PRE_ALLBANK;
    end else if (s == 2) begin
      code_o = CMD_MRS;
      sel_o  = SEL_EMR2;
    end else if (s == 3) begin
      code_o = CMD_MRS;
      sel_o  = SEL_EMR3;
    end else if (s == 4) begin
      code_o = CMD_MRS;
      sel_o  = SEL_EMR;
      word   = emr_i;
    end else if (s == 5) begin
      code_o       = CMD_MRS;
      word         = mr_i | MR_DLL_RST;
      wait_after_o = 1'b1;
    end else if (s >= S_REF0 && s < S_MR2) begin
      code_o = CMD_REF;
    end else if (s == S_MR2) begin
      code_o = CMD_MRS;
      word   = mr_i;
    end else if (s == S_OCD) begin
      code_o = CMD_MRS;
      sel_o  = SEL_EMR;
      word   = emr_i | EMR_OCD_DEF;
    end else if (s == S_EXIT) begin
      code_o = CMD_MRS;
      sel_o  = SEL_EMR;
      word   = emr_i;
      last_o = 1'b1;
    end
    addr_o = ADDR_W'(word);
  end
endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (load_i) cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL); // R6
  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !load_i && !expired_o |=> cnt_q == $past(cnt_q) - 1'b1); // R6
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WAIT_CYC  = 16,
  parameter int REF_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        wr_rec_i,
  input  logic [1:0]        mod_cnt_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_code_o,
  output logic [1:0]        cmd_sel_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  localparam int NUM_STEPS = 10 + REF_COUNT;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [WORD_W-1:0] mr_q, emr_q;
  logic              err_q;

  logic              cfg_ok;
  logic [WORD_W-1:0] mr_new, emr_new;
  logic              wait_after, last_step, wait_expired;

  // named events
  logic idle_like, start_take, start_reject, handshake, enter_wait;

  ddr2_mode_words u_words (
    .cas_lat_i (cas_lat_i),
    .wr_rec_i  (wr_rec_i),
    .mod_cnt_i (mod_cnt_i),
    .cfg_ok_o  (cfg_ok),
    .mr_o      (mr_new),
    .emr_o     (emr_new)
  );

  ddr2_step_decode #(
    .ADDR_W    (ADDR_W),
    .REF_COUNT (REF_COUNT),
    .STEP_W    (STEP_W)
  ) u_decode (
    .step_i       (step_q),
    .mr_i         (mr_q),
    .emr_i        (emr_q),
    .code_o       (cmd_code_o),
    .sel_o        (cmd_sel_o),
    .addr_o       (cmd_addr_o),
    .wait_after_o (wait_after),
    .last_o       (last_step)
  );

  assign idle_like    = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign start_take   = idle_like && start_i && cfg_ok;
  assign start_reject = idle_like && start_i && !cfg_ok;
  assign cmd_valid_o  = (state_q == ST_ISSUE);
  assign handshake    = cmd_valid_o && cmd_ready_i;
  assign enter_wait   = handshake && wait_after && !last_step;

  ddr2_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (enter_wait),
    .run_i     (state_q == ST_WAIT),
    .expired_o (wait_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      mr_q    <= '0;
      emr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_take) begin
            state_q <= ST_ISSUE;
            step_q  <= '0;
            mr_q    <= mr_new;
            emr_q   <= emr_new;
            err_q   <= 1'b0;
          end else if (start_reject) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
        ST_ISSUE: begin
          if (handshake) begin
            if (last_step) begin
              state_q <= ST_DONE;
            end else begin
              step_q <= step_q + STEP_W'(1);
              if (wait_after) state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (wait_expired) state_q <= ST_ISSUE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign done_o    = (state_q == ST_DONE);
  assign cfg_err_o = err_q;

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_code_o)
      && $stable(cmd_sel_o) && $stable(cmd_addr_o)); // R7
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WAIT |-> !cmd_valid_o); // R6
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_code_o == CMD_NOP || cmd_code_o == CMD_PRE
      || cmd_code_o == CMD_REF || cmd_code_o == CMD_MRS)); // R2
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> cfg_err_o && !cmd_valid_o && !busy_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o && !busy_o); // R8
  AST_STEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> $stable(step_q)); // R10
  AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mr_q) && $stable(emr_q)); // R11
endmodule

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 14;
  localparam int WAIT_CYC   = 5;
  localparam int REF_COUNT  = 4;

  typedef struct {
    logic [2:0]        code;
    logic [1:0]        sel;
    logic [ADDR_W-1:0] addr;
    int                gap;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cas = 3'd3;
  logic [2:0] wr = 3'd3;
  logic [1:0] mods = 2'd1;
  logic rdy = 1'b1;
  logic valid, busy, done, err;
  logic [2:0] code;
  logic [1:0] sel;
  logic [ADDR_W-1:0] addr;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;
  int pat = 0;
  bit finished = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_init_seq #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .REF_COUNT(REF_COUNT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cas_lat_i(cas), .wr_rec_i(wr),
    .mod_cnt_i(mods), .cmd_valid_o(valid), .cmd_ready_i(rdy), .cmd_code_o(code),
    .cmd_sel_o(sel), .cmd_addr_o(addr), .busy_o(busy), .done_o(done), .cfg_err_o(err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (ready_mode == 0) rdy = 1'b1;
      else begin
        rdy = (pat % 3) != 1;
        pat++;
      end
    end
  end

  // monitor / scoreboard
  int last_hs = 0;
  bit prev_stall = 0;
  logic [2:0] p_code;
  logic [1:0] p_sel;
  logic [ADDR_W-1:0] p_addr;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin // R7
          check("R7", "valid held", int'(valid), 1);
          check("R7", "code held", int'(code), int'(p_code));
          check("R7", "addr held", int'(addr), int'(p_addr));
          check("R7", "sel held", int'(sel), int'(p_sel));
        end
        prev_stall = valid && !rdy;
        p_code = code; p_sel = sel; p_addr = addr;
        if (valid && rdy) begin
          if (q.size() == 0) begin
            check("R2", "unexpected command code", int'(code), -1);
          end else begin
            item_t e;
            e = q.pop_front();
            check("R2", "command code", int'(code), int'(e.code));
            check("R2", "select", int'(sel), int'(e.sel));
            check("R3", "address word", int'(addr), int'(e.addr));
            if (e.gap > 0) check("R6", "handshake gap", cyc - last_hs, e.gap);
          end
          last_hs = cyc;
        end
      end
    end
  end

  task automatic push(input logic [2:0] c, input logic [1:0] s, input int a, input int g);
    item_t it;
    it.code = c; it.sel = s; it.addr = ADDR_W'(a); it.gap = g;
    q.push_back(it);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  // expected sequence from R2..R6
  task automatic run_seq(input int c, input int w, input int m, input int mode, input bit meddle);
    int mr, emr, g, gw;
    mr  = (w - 1) * 512 + c * 16 + 2;
    emr = (m == 1) ? 64 : 6;
    g   = (mode == 0) ? 1 : 0;
    gw  = (mode == 0) ? WAIT_CYC + 1 : 0;
    ready_mode = mode;
    cas = 3'(c); wr = 3'(w); mods = 2'(m);
    push(3'd7, 2'd0, 0, 0);
    push(3'd2, 2'd0, 'h400, gw);
    push(3'd0, 2'd2, 0, g);
    push(3'd0, 2'd3, 0, g);
    push(3'd0, 2'd1, emr, g);
    push(3'd0, 2'd0, mr + 'h100, g);
    push(3'd2, 2'd0, 'h400, gw);
    for (int i = 0; i < REF_COUNT; i++) push(3'd1, 2'd0, 0, g);
    push(3'd0, 2'd0, mr, g);
    push(3'd0, 2'd1, emr + 'h380, g);
    push(3'd0, 2'd1, emr, g);
    pulse_start();
    @(negedge clk);
    check("R8", "busy after start", int'(busy), 1);
    check("R8", "done after start", int'(done), 0);
    check("R9", "err cleared by valid start", int'(err), 0);
    if (meddle) begin
      repeat (8) @(posedge clk);
      #1 cas = 3'd4; wr = 3'd2; mods = 2'(3 - m); // R11 inputs change mid-run
      pulse_start();                              // R10 start while busy
    end
    while (!done) @(negedge clk);
    check("R2", "leftover expected commands", q.size(), 0);
    check("R8", "busy at done", int'(busy), 0);
    repeat (10) @(negedge clk);
    check("R8", "done holds", int'(done), 1);
  endtask

  task automatic bad_start(input int c, input int w, input int m);
    int stray = 0;
    cas = 3'(c); wr = 3'(w); mods = 2'(m);
    pulse_start();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (valid || busy) stray++;
    end
    check("R9", "error flag", int'(err), 1);
    check("R9", "commands after bad config", stray, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(valid), 0);
    check("R1", "busy in reset", int'(busy), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", int'(valid), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "err after reset", int'(err), 0);
    check("R1", "busy after reset", int'(busy), 0);

    run_seq(3, 3, 1, 0, 0);      // R4 one module, R6 exact gaps
    run_seq(5, 6, 2, 1, 1);      // R4 two modules, R7 stalls, R10, R11
    bad_start(6, 3, 1);          // R9 CAS too large
    bad_start(4, 3, 0);          // R9 no module
    bad_start(4, 7, 2);          // R9 write recovery too large
    bad_start(2, 1, 3);          // R9 all out of range
    run_seq(4, 2, 2, 0, 0);      // R3 lowest write recovery, R5
    run_seq(3, 5, 1, 1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule